// File: doc/BRIEF.md
# Oversampling Serial Receiver with Parity and Framing Checks

This block recovers asynchronous serial characters from a single idle-high line. The line is oversampled by a fixed number of system clocks per bit (16 by default). A high-to-low transition starts a frame. Each following bit is sampled once, in the middle of its period. Word length (5 to 8 bits), parity checking and the number of stop bits are selected by static configuration inputs. These inputs are shared with a companion transmitter and are captured when each frame begins.

When the last stop bit has been sampled, the block raises a ready flag. It also presents the word together with two error flags, one for a parity mismatch and one for a bad stop bit. A host reads the word over a small tri-stated bus by asserting chip select (active low) and a read strobe. That read clears the ready flag. Bits are shifted in from the top of the word, so a short word is left-aligned.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, rx_ready, parity_err and frame_err are low, and no frame is in progress.
- R2: An 8-bit frame (len_sel = 3) sent least significant bit first is returned unchanged on data_io during a read.
- R3: len_sel selects len_sel+5 data bits. The received bits occupy the top of the 8-bit word and the lower bits read as zero (five bits 00101 read as 0x28).
- R4: With parity enabled, parity_err is set when the received parity bit differs from the XOR of the received data bits. With parity disabled, parity_err is low.
- R5: frame_err is set when the first stop bit is sampled low.
- R6: With two stop bits selected, a low second stop bit also sets frame_err. Two high stop bits leave it clear.
- R7: A low pulse shorter than half a bit period on an idle line starts no frame, and rx_ready stays low.
- R8: rx_ready is low at the start of the final stop bit. It is high before that bit ends, and it stays high until a read.
- R9: A read is rd high while cs_n is low. It drives the word on data_io and clears rx_ready on the next clock. rd high with cs_n high leaves rx_ready set.
- R10: The error flags describe only the most recent frame. A clean frame after a faulty one clears both flags.
- R11: Framing settings are captured at the start bit. Changing len_sel during a frame does not change that frame's bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, OVERSAMPLE periods per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| len_sel | input | 2 | Data bits minus five |
| parity_en | input | 1 | Expect a parity bit after the data |
| two_stop | input | 1 | Expect and check a second stop bit |
| cs_n | input | 1 | Chip select, active low |
| rd | input | 1 | Read strobe |
| data_io | inout | 8 | Received word while read, else high impedance |
| rx_ready | output | 1 | A new word is waiting |
| parity_err | output | 1 | Parity mismatch in the held word |
| frame_err | output | 1 | Low stop bit in the held word |

## Verification
A wrong bit counter or a wrong latched length shows up as a shifted or truncated word at the next read, one frame after the fault. A wrong sample point or a wrong parity accumulator appears on the flags at that same read. A stuck ready flag is caught at the port within one clock of a read. A start detector that accepts glitches raises rx_ready about one frame time after a short pulse.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    parameter int RX_WORD_W   = 8;
    parameter int RX_MIN_BITS = 5;
    localparam int RX_IDX_W   = $clog2(RX_WORD_W);

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
    } rx_state_e;

    typedef struct packed {
        rx_state_e              state;
        logic                   rx_prev;
        logic [RX_IDX_W-1:0]    bit_idx;
        logic [RX_IDX_W-1:0]    last_idx;
        logic                   par_on;
        logic                   two_on;
        logic [RX_WORD_W-1:0]   shreg;
        logic                   par_acc;
        logic                   perr_w;
        logic                   ferr_w;
        logic [RX_WORD_W-1:0]   word;
        logic                   perr;
        logic                   ferr;
        logic                   ready;
    } rx_regs_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_timer.sv
module serial_rx_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mid
);
    localparam int CW   = $clog2(OVERSAMPLE);
    localparam int HALF = OVERSAMPLE / 2;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)                               cnt_d = '0;
        else if (cnt_q == CW'(OVERSAMPLE - 1))  cnt_d = '0;
        else                                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign mid = run && (cnt_q == CW'(HALF - 1));
endmodule

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
    import serial_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_s,
    input  logic                 mid,
    input  logic [1:0]           len_sel,
    input  logic                 parity_en,
    input  logic                 two_stop,
    input  logic                 read_req,
    output rx_state_e            state,
    output logic                 frame_done,
    output logic [RX_WORD_W-1:0] word,
    output logic                 perr,
    output logic                 ferr,
    output logic                 ready
);
    rx_regs_t q, d;
    logic done;

    always_comb begin
        d       = q;
        done    = 1'b0;
        d.rx_prev = rx_s;
        case (q.state)
            ST_IDLE: begin
                if (q.rx_prev && !rx_s) begin
                    d.state    = ST_START;
                    d.par_on   = parity_en;
                    d.two_on   = two_stop;
                    d.last_idx = RX_IDX_W'(len_sel) + RX_IDX_W'(RX_MIN_BITS - 1);
                    d.bit_idx  = '0;
                    d.shreg    = '0;
                    d.par_acc  = 1'b0;
                    d.perr_w   = 1'b0;
                    d.ferr_w   = 1'b0;
                end
            end
            ST_START: begin
                if (mid) d.state = rx_s ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (mid) begin
                    d.shreg   = {rx_s, q.shreg[RX_WORD_W-1:1]};
                    d.par_acc = q.par_acc ^ rx_s;
                    d.bit_idx = q.bit_idx + 1'b1;
                    if (q.bit_idx == q.last_idx)
                        d.state = q.par_on ? ST_PAR : ST_STOP1;
                end
            end
            ST_PAR: begin
                if (mid) begin
                    d.perr_w = rx_s ^ q.par_acc;
                    d.state  = ST_STOP1;
                end
            end
            ST_STOP1: begin
                if (mid) begin
                    d.ferr_w = !rx_s;
                    if (q.two_on) d.state = ST_STOP2;
                    else          done    = 1'b1;
                end
            end
            ST_STOP2: begin
                if (mid) begin
                    d.ferr_w = q.ferr_w | !rx_s;
                    done     = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (done) begin
            d.state = ST_IDLE;
            d.word  = d.shreg;
            d.perr  = d.perr_w;
            d.ferr  = d.ferr_w;
            d.ready = 1'b1;
        end else if (read_req) begin
            d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_IDLE;
            q.rx_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign state      = q.state;
    assign frame_done = done;
    assign word       = q.word;
    assign perr       = q.perr;
    assign ferr       = q.ferr;
    assign ready      = q.ready;
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic [1:0] len_sel,
    input  logic       parity_en,
    input  logic       two_stop,
    input  logic       cs_n,
    input  logic       rd,
    inout  wire  [7:0] data_io,
    output logic       rx_ready,
    output logic       parity_err,
    output logic       frame_err
);
    logic                 rx_s;
    logic                 mid_tick;
    logic                 read_req;
    logic                 frame_done;
    rx_state_e            state;
    logic [RX_WORD_W-1:0] word;

    assign read_req = rd && !cs_n;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
    );

    serial_rx_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .mid(mid_tick)
    );

    serial_rx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .mid(mid_tick),
        .len_sel(len_sel), .parity_en(parity_en), .two_stop(two_stop),
        .read_req(read_req), .state(state), .frame_done(frame_done),
        .word(word), .perr(parity_err), .ferr(frame_err), .ready(rx_ready)
    );

    assign data_io = read_req ? word : 8'bz;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker
    import serial_rx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 rd,
    input logic                 rx_ready,
    input logic                 frame_done,
    input logic [RX_WORD_W-1:0] word,
    input rx_state_e            state,
    input logic                 mid,
    input logic                 rx_s
);
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && !(rd && !cs_n) |=> rx_ready); // R8

    AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rx_ready); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !cs_n && !frame_done |=> !rx_ready); // R9

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready && !frame_done |=> $stable(word)); // R2

    AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_START && mid && rx_s |=> state == ST_IDLE); // R7
endmodule

bind serial_rx_unit serial_rx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd(rd), .rx_ready(rx_ready),
    .frame_done(frame_done), .word(word), .state(state), .mid(mid_tick),
    .rx_s(rx_s)
);

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;
    localparam int BIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic       parity_en = 1'b0;
    logic       two_stop = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd = 1'b0;
    wire  [7:0] data_io;
    logic       rx_ready, parity_err, frame_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic ready_at_last_stop;

    always #10 clk = ~clk;

    serial_rx_unit i_serial_rx_unit (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .len_sel(len_sel),
        .parity_en(parity_en), .two_stop(two_stop), .cs_n(cs_n), .rd(rd),
        .data_io(data_io), .rx_ready(rx_ready), .parity_err(parity_err),
        .frame_err(frame_err)
    );

    typedef struct packed {
        logic [7:0] data;
        logic [1:0] len;
        logic       par;
        logic       bad;
        logic       s1;
        logic       two;
        logic       s2;
        logic       eperr;
        logic       eferr;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'hA6, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h69, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hE5, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'h05, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h3C, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h55, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'h12, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{8'h7E, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{8'h33, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] left_align(input logic [7:0] data, input logic [1:0] len);
        int n = int'(len) + 5;
        logic [7:0] m = data & 8'((1 << n) - 1);
        return m << (8 - n);
    endfunction

    task automatic hold_bit(input logic v);
        rx_line = v;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] data, input logic [1:0] len, input logic par,
                        input logic bad, input logic s1, input logic two, input logic s2,
                        input bit swap_len, input logic [1:0] alt_len);
        int n = int'(len) + 5;
        logic p = 1'b0;
        @(negedge clk);
        len_sel = len; parity_en = par; two_stop = two;
        hold_bit(1'b0);
        if (swap_len) len_sel = alt_len;
        for (int i = 0; i < n; i++) begin
            p ^= data[i];
            hold_bit(data[i]);
        end
        if (par) hold_bit(p ^ bad);
        if (two) begin
            hold_bit(s1);
            ready_at_last_stop = rx_ready;
            hold_bit(s2);
        end else begin
            ready_at_last_stop = rx_ready;
            hold_bit(s1);
        end
        rx_line = 1'b1;
        len_sel = len;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] w, output logic pe, output logic fe);
        @(negedge clk);
        cs_n = 1'b0; rd = 1'b1;
        #1;
        w = data_io; pe = parity_err; fe = frame_err;
        @(negedge clk);
        cs_n = 1'b1; rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] w;
        logic pe, fe;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rx_ready == 1'b0, "R1", "ready in reset", rx_ready, 0);
        chk(parity_err == 1'b0 && frame_err == 1'b0, "R1", "flags in reset",
            {parity_err, frame_err}, 0);
        rst_n = 1'b1;
        repeat (4 * BIT) @(negedge clk);
        chk(rx_ready == 1'b0, "R1", "ready idle after reset", rx_ready, 0);

        for (int k = 0; k < 10; k++) begin
            vec_t v = VECS[k];
            send(v.data, v.len, v.par, v.bad, v.s1, v.two, v.s2, 1'b0, 2'd0);
            chk(ready_at_last_stop == 1'b0, "R8", "ready before last stop", ready_at_last_stop, 0);
            chk(rx_ready == 1'b1, "R8", "ready after frame", rx_ready, 1);
            do_read(w, pe, fe);
            chk(w == left_align(v.data, v.len), "R2 R3", "word", w, left_align(v.data, v.len));
            chk(pe == v.eperr, "R4 R10", "parity flag", pe, v.eperr);
            chk(fe == v.eferr, "R5 R6 R10", "frame flag", fe, v.eferr);
            chk(rx_ready == 1'b0, "R9", "ready after read", rx_ready, 0);
        end

        // R7: short low pulse on idle line
        @(negedge clk);
        len_sel = 2'd3; parity_en = 1'b0; two_stop = 1'b0;
        rx_line = 1'b0;
        repeat (5) @(negedge clk);
        rx_line = 1'b1;
        repeat (12 * BIT) @(negedge clk);
        chk(rx_ready == 1'b0, "R7", "ready after glitch", rx_ready, 0);

        // R9: rd without chip select leaves ready set
        send(8'hC3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0);
        chk(rx_ready == 1'b1, "R7", "frame after glitch", rx_ready, 1);
        @(negedge clk);
        rd = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        chk(rx_ready == 1'b1, "R9", "ready kept without select", rx_ready, 1);
        repeat (BIT) @(negedge clk);
        chk(rx_ready == 1'b1, "R8", "ready held until read", rx_ready, 1);
        do_read(w, pe, fe);
        chk(w == 8'hC3, "R9", "word on read", w, 8'hC3);

        // R11: len_sel changed after start bit
        send(8'h96, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0);
        do_read(w, pe, fe);
        chk(w == 8'h96, "R11", "word with mid-frame len change", w, 8'h96);
        chk(fe == 1'b0, "R11", "frame flag with mid-frame len change", fe, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule